// File: doc/BRIEF.md
# Integer Execution Unit with Guarded Division

This block is the integer execution stage of a 64-bit register machine. On a start pulse it takes an operation code, a width mode (64-bit or 32-bit), a 16-bit offset field, the current destination register value, a source register value, a 32-bit immediate and a source-select bit. It writes the new destination value to a registered result and pulses `done`. Addition, subtraction, multiplication, bitwise logic, shifts, negation, plain and sign-extending moves and byte-order conversion finish one cycle after start.

Division and modulus, unsigned or signed, run on a bit-serial restoring divider. The unit holds `busy` high while it works and ignores `start` during that time. Division never traps. A zero divisor and the overflow case (most-negative value divided by minus one) give fixed results in one cycle and do not start the divider.

Top module: `xalu_core`

## Requirements
- R1: After reset, `busy` and `done` are 0 and `result` is all zeros.
- R2: With `wide`=0, operands use their low 32 bits, results wrap at 32 bits and result bits 63:32 are zero, for every operation except byte conversion. With `wide`=1, results wrap at 64 bits.
- R3: The `op` codes are 0 add, 1 subtract (dst-src), 2 multiply (low half), 4 or, 5 and, 10 xor, 8 negate (-dst, source ignored) and 11 move (result = source).
- R4: Codes 6 (left), 7 (logical right) and 12 (arithmetic right, sign fill at the active width) shift dst. The shift count is the source masked to 6 bits when `wide`=1 and to 5 bits when `wide`=0.
- R5: With `src_sel`=1 the source is `src_val`. With `src_sel`=0 it is `imm`, sign-extended to 64 bits when `wide`=1 (also for unsigned divide and modulus) and zero-extended when `wide`=0.
- R6: Code 3 divides and code 9 takes the remainder. Both are unsigned when `off` is 0 and signed when `off` is 1. Signed forms truncate toward zero, so the remainder has the dividend's sign (-13 rem 3 = -1).
- R7: Division by zero gives 0. Modulus by zero gives dst unchanged, with bits 63:32 zeroed when `wide`=0.
- R8: Signed division of the most-negative value of the active width by -1 gives that most-negative value. The matching signed modulus gives 0.
- R9: Code 11 with `off` 8, 16 or 32 sign-extends that many low bits of `src_val` (whatever `src_sel` is) to 64 bits, or to 32 bits with the upper half zeroed when `wide`=0.
- R10: Code 13 converts byte order over a width of `imm` = 16, 32 or 64 bits. With `wide`=0 and `src_sel`=0 it keeps only the low bytes of that width, zero-extended. With `wide`=0 and `src_sel`=1, or with `wide`=1, it reverses the byte order within that width and zeroes the bits above it. Other `imm` values leave dst unchanged.
- R11: `done` pulses for one cycle. Non-divide operations and guarded divides (R7, R8) raise it one cycle after the start edge. Other divides and moduli hold `busy` and raise `done` exactly XLEN+1 cycles after the start edge.
- R12: A `start` while `busy` is high is ignored: it changes neither the running result nor its timing.
- R13: `result` changes only in the cycle where `done` is high and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation with the present inputs |
| op | input | 4 | Operation code |
| wide | input | 1 | 1: 64-bit mode, 0: 32-bit mode |
| src_sel | input | 1 | 1: register source, 0: immediate source |
| off | input | 16 | Offset field: signed divide select, sign-extend width |
| dst_val | input | 64 | Current destination register value |
| src_val | input | 64 | Source register value |
| imm | input | 32 | Immediate value, or byte-conversion width |
| busy | output | 1 | Divider iterating |
| done | output | 1 | One-cycle pulse: `result` has been updated |
| result | output | 64 | New destination value |

## Verification
The assertions check the divider's timing and state on every cycle. `busy` must stay high until the final step and drop together with a `done` pulse. The partial remainder must stay below the divisor. The divisor must not change while `busy` is high, so a start during that time has no effect. `result` may move only when `done` is high, and bits 63:32 must be zero for 32-bit results. Only the bench's sweeps can show that the values are correct: every code over a grid of extreme operands in both widths, both source kinds, the zero-divisor and overflow guards, the sign-extend widths and the byte-conversion forms.

// File: rtl/xalu_pkg.sv
package xalu_pkg;
    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_MUL  = 4'd2,
        OP_DIV  = 4'd3,
        OP_OR   = 4'd4,
        OP_AND  = 4'd5,
        OP_LSH  = 4'd6,
        OP_RSH  = 4'd7,
        OP_NEG  = 4'd8,
        OP_MOD  = 4'd9,
        OP_XOR  = 4'd10,
        OP_MOV  = 4'd11,
        OP_ARSH = 4'd12,
        OP_END  = 4'd13
    } xalu_op_e;

    localparam int unsigned SX_W8  = 8;
    localparam int unsigned SX_W16 = 16;
    localparam int unsigned SX_W32 = 32;
endpackage

// File: rtl/xalu_opnd.sv
module xalu_opnd #(
    parameter int XLEN = 64
) (
    input  logic            wide,
    input  logic            src_sel,
    input  logic [XLEN-1:0] dst_val,
    input  logic [XLEN-1:0] src_val,
    input  logic [XLEN/2-1:0] imm,
    output logic [XLEN-1:0] a,
    output logic [XLEN-1:0] b,
    output logic [XLEN-1:0] a_sx,
    output logic [XLEN-1:0] b_sx
);
    localparam int HALF = XLEN / 2;

    logic [XLEN-1:0] src_raw;

    always_comb begin
        src_raw = src_sel ? src_val : {{HALF{imm[HALF-1]}}, imm};
        a       = wide ? dst_val : {{HALF{1'b0}}, dst_val[HALF-1:0]};
        b       = wide ? src_raw : {{HALF{1'b0}}, src_raw[HALF-1:0]};
        a_sx    = wide ? a : {{HALF{a[HALF-1]}}, a[HALF-1:0]};
        b_sx    = wide ? b : {{HALF{b[HALF-1]}}, b[HALF-1:0]};
    end
endmodule

// File: rtl/xalu_simple.sv
module xalu_simple
    import xalu_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [3:0]        op,
    input  logic              wide,
    input  logic              src_sel,
    input  logic [15:0]       off,
    input  logic [XLEN-1:0]   dst_val,
    input  logic [XLEN/2-1:0] src_lo,
    input  logic [XLEN/2-1:0] imm,
    input  logic [XLEN-1:0]   a,
    input  logic [XLEN-1:0]   b,
    output logic [XLEN-1:0]   res
);
    localparam int HALF  = XLEN / 2;
    localparam int SHW   = $clog2(XLEN);
    localparam int NBYTE = XLEN / 8;

    logic [SHW-1:0]  sh;
    logic [XLEN-1:0] raw;
    logic [XLEN-1:0] swapped;
    logic [XLEN-1:0] kept;
    int              nb;

    always_comb begin
        sh = wide ? b[SHW-1:0] : {1'b0, b[SHW-2:0]};

        case (imm)
            32'd16:  nb = 2;
            32'd32:  nb = 4;
            32'd64:  nb = 8;
            default: nb = 0;
        endcase
        swapped = '0;
        kept    = '0;
        for (int i = 0; i < NBYTE; i++) begin
            if (i < nb) begin
                swapped[8*i +: 8] = dst_val[8*(nb-1-i) +: 8];
                kept[8*i +: 8]    = dst_val[8*i +: 8];
            end
        end

        case (xalu_op_e'(op))
            OP_ADD:  raw = a + b;
            OP_SUB:  raw = a - b;
            OP_MUL:  raw = a * b;
            OP_OR:   raw = a | b;
            OP_AND:  raw = a & b;
            OP_XOR:  raw = a ^ b;
            OP_NEG:  raw = -a;
            OP_LSH:  raw = a << sh;
            OP_RSH:  raw = a >> sh;
            OP_ARSH: raw = wide ? XLEN'($signed(a) >>> sh)
                                : {{HALF{1'b0}}, HALF'($signed(a[HALF-1:0]) >>> sh[SHW-2:0])};
            OP_MOV: begin
                case (off)
                    16'(SX_W8):  raw = {{(XLEN-8){src_lo[7]}}, src_lo[7:0]};
                    16'(SX_W16): raw = {{(XLEN-16){src_lo[15]}}, src_lo[15:0]};
                    16'(SX_W32): raw = {{HALF{src_lo[HALF-1]}}, src_lo};
                    default:     raw = b;
                endcase
            end
            OP_END: begin
                if (nb == 0)                 raw = dst_val;
                else if (!wide && !src_sel)  raw = kept;
                else                         raw = swapped;
            end
            default: raw = '0;
        endcase

        if (!wide && xalu_op_e'(op) != OP_END) res = {{HALF{1'b0}}, raw[HALF-1:0]};
        else                                   res = raw;
    end
endmodule

// File: rtl/xalu_divstep.sv
module xalu_divstep #(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] rem_in,
    input  logic [XLEN-1:0] quo_in,
    input  logic [XLEN-1:0] dvs,
    output logic [XLEN-1:0] rem_out,
    output logic [XLEN-1:0] quo_out
);
    logic [XLEN:0] shifted;
    logic [XLEN:0] diff;
    logic          ge;

    always_comb begin
        shifted = {rem_in, quo_in[XLEN-1]};
        diff    = shifted - {1'b0, dvs};
        ge      = shifted >= {1'b0, dvs};
        rem_out = ge ? diff[XLEN-1:0] : shifted[XLEN-1:0];
        quo_out = {quo_in[XLEN-2:0], ge};
    end
endmodule

// File: rtl/xalu_core.sv
module xalu_core
    import xalu_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [3:0]      op,
    input  logic            wide,
    input  logic            src_sel,
    input  logic [15:0]     off,
    input  logic [63:0]     dst_val,
    input  logic [63:0]     src_val,
    input  logic [31:0]     imm,
    output logic            busy,
    output logic            done,
    output logic [63:0]     result
);
    localparam int HALF = XLEN / 2;
    localparam int CW   = $clog2(XLEN + 1);
    localparam logic [CW-1:0] LAST = CW'(XLEN - 1);
    localparam logic [XLEN-1:0] MIN_W = {1'b1, {(XLEN-1){1'b0}}};
    localparam logic [XLEN-1:0] MIN_H = {{(HALF+1){1'b1}}, {(HALF-1){1'b0}}};

    typedef struct packed {
        logic            busy;
        logic            done;
        logic [CW-1:0]   cnt;
        logic [XLEN-1:0] rem;
        logic [XLEN-1:0] quo;
        logic [XLEN-1:0] dvs;
        logic            neg_q;
        logic            neg_r;
        logic            is_mod;
        logic            wide;
        logic            zhi;
        logic [XLEN-1:0] result;
    } st_t;

    st_t st_d, st_q;

    logic [XLEN-1:0] a, b, a_sx, b_sx, simple_res;
    logic [XLEN-1:0] rem_nx, quo_nx;
    logic [XLEN-1:0] dd, dv, fin;
    logic            is_div, sgn, by_zero, ovf;

    xalu_opnd #(.XLEN(XLEN)) u_opnd (
        .wide(wide), .src_sel(src_sel), .dst_val(dst_val), .src_val(src_val),
        .imm(imm), .a(a), .b(b), .a_sx(a_sx), .b_sx(b_sx)
    );

    xalu_simple #(.XLEN(XLEN)) u_simple (
        .op(op), .wide(wide), .src_sel(src_sel), .off(off), .dst_val(dst_val),
        .src_lo(src_val[HALF-1:0]), .imm(imm), .a(a), .b(b), .res(simple_res)
    );

    xalu_divstep #(.XLEN(XLEN)) u_step (
        .rem_in(st_q.rem), .quo_in(st_q.quo), .dvs(st_q.dvs),
        .rem_out(rem_nx), .quo_out(quo_nx)
    );

    always_comb begin
        is_div  = (xalu_op_e'(op) == OP_DIV) || (xalu_op_e'(op) == OP_MOD);
        sgn     = (off == 16'd1);
        by_zero = (b == '0);
        ovf     = sgn && (a_sx == (wide ? MIN_W : MIN_H)) && (b_sx == '1);
        dd      = sgn ? a_sx : a;
        dv      = sgn ? b_sx : b;

        fin = st_q.is_mod ? (st_q.neg_r ? -rem_nx : rem_nx)
                          : (st_q.neg_q ? -quo_nx : quo_nx);
        if (!st_q.wide) fin = {{HALF{1'b0}}, fin[HALF-1:0]};

        st_d      = st_q;
        st_d.done = 1'b0;
        if (st_q.busy) begin
            st_d.rem = rem_nx;
            st_d.quo = quo_nx;
            st_d.cnt = st_q.cnt + 1'b1;
            if (st_q.cnt == LAST) begin
                st_d.busy   = 1'b0;
                st_d.done   = 1'b1;
                st_d.result = fin;
            end
        end else if (start) begin
            st_d.zhi  = !wide && (xalu_op_e'(op) != OP_END);
            st_d.wide = wide;
            if (!is_div) begin
                st_d.result = simple_res;
                st_d.done   = 1'b1;
            end else if (by_zero || ovf) begin
                st_d.done = 1'b1;
                if (xalu_op_e'(op) == OP_DIV) st_d.result = by_zero ? '0 : a;
                else                          st_d.result = by_zero ? a : '0;
            end else begin
                st_d.busy   = 1'b1;
                st_d.cnt    = '0;
                st_d.rem    = '0;
                st_d.quo    = (sgn && dd[XLEN-1]) ? -dd : dd;
                st_d.dvs    = (sgn && dv[XLEN-1]) ? -dv : dv;
                st_d.neg_q  = sgn && (dd[XLEN-1] ^ dv[XLEN-1]);
                st_d.neg_r  = sgn && dd[XLEN-1];
                st_d.is_mod = (xalu_op_e'(op) == OP_MOD);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy   = st_q.busy;
    assign done   = st_q.done;
    assign result = st_q.result;

    a_r11_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && st_q.cnt != LAST) |=> (busy && !done));
    a_r11_finish: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && st_q.cnt == LAST) |=> (done && !busy));
    a_r6_rem_below_divisor: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy |-> (st_q.rem < st_q.dvs));
    a_r12_divisor_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy |=> $stable(st_q.dvs));
    a_r13_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(result));
    a_r2_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (done && st_q.zhi) |-> (result[63:32] == 32'd0));
endmodule

// File: tb/tb_xalu_core.sv
module tb_xalu_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  op = '0;
    logic        wide = 1'b0;
    logic        src_sel = 1'b0;
    logic [15:0] off = '0;
    logic [63:0] dst_val = '0;
    logic [63:0] src_val = '0;
    logic [31:0] imm = '0;
    logic        busy, done;
    logic [63:0] result;

    int checks = 0;
    int errors = 0;

    xalu_core dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .wide(wide),
        .src_sel(src_sel), .off(off), .dst_val(dst_val), .src_val(src_val),
        .imm(imm), .busy(busy), .done(done), .result(result)
    );

    always #5ns clk = ~clk;

    logic [63:0] vals [12] = '{
        64'h0, 64'h1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000,
        64'h7FFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_8000_0000, 64'h0000_0000_7FFF_FFFF,
        64'hFFFF_FFFF_FFFF_FFF3, 64'h3, 64'h0123_4567_89AB_CDEF,
        64'h0000_0000_8000_0000, 64'hFEDC_BA98_0000_0025
    };
    logic [31:0] imms [6] = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'h8000_0000,
                              32'h0000_0003, 32'hFFFF_FFF3};

    function automatic logic [63:0] z32(input logic [63:0] x);
        return {32'd0, x[31:0]};
    endfunction

    function automatic bit guarded(input logic [3:0] o, input bit w, input bit s,
                                   input logic [15:0] f, input logic [63:0] d,
                                   input logic [63:0] sv, input logic [31:0] im);
        logic [63:0] av, bv;
        longint sa, sb;
        av = w ? d : z32(d);
        bv = s ? sv : (w ? {{32{im[31]}}, im} : {32'd0, im});
        if (!w) bv = z32(bv);
        sa = w ? $signed(av) : longint'($signed(av[31:0]));
        sb = w ? $signed(bv) : longint'($signed(bv[31:0]));
        if (bv == 0) return 1;
        if (f == 16'd1 && sb == -1 &&
            (w ? (av == 64'h8000_0000_0000_0000) : (sa == -64'sd2147483648))) return 1;
        return 0;
    endfunction

    function automatic logic [63:0] model(input logic [3:0] o, input bit w, input bit s,
                                          input logic [15:0] f, input logic [63:0] d,
                                          input logic [63:0] sv, input logic [31:0] im);
        logic [63:0] av, bv, r;
        longint sa, sb;
        int sh, nbytes;
        bit sgn;
        av  = w ? d : z32(d);
        bv  = s ? sv : (w ? {{32{im[31]}}, im} : {32'd0, im});
        if (!w) bv = z32(bv);
        sa  = w ? $signed(av) : longint'($signed(av[31:0]));
        sb  = w ? $signed(bv) : longint'($signed(bv[31:0]));
        sgn = (f == 16'd1);
        sh  = w ? int'(bv[5:0]) : int'(bv[4:0]);
        r   = 0;
        case (o)
            4'd0:  r = av + bv;
            4'd1:  r = av - bv;
            4'd2:  r = av * bv;
            4'd4:  r = av | bv;
            4'd5:  r = av & bv;
            4'd10: r = av ^ bv;
            4'd8:  r = 64'd0 - av;
            4'd6:  r = av << sh;
            4'd7:  r = av >> sh;
            4'd12: r = w ? 64'($signed(av) >>> sh) : 64'(sa >>> sh);
            4'd11: begin
                if (f == 16'd8)       r = 64'(longint'($signed(sv[7:0])));
                else if (f == 16'd16) r = 64'(longint'($signed(sv[15:0])));
                else if (f == 16'd32) r = 64'(longint'($signed(sv[31:0])));
                else                  r = bv;
            end
            4'd3: begin
                if (bv == 0)               r = 0;
                else if (guarded(o, w, s, f, d, sv, im)) r = av;
                else if (sgn)              r = 64'(sa / sb);
                else                       r = av / bv;
            end
            4'd9: begin
                if (bv == 0)               r = av;
                else if (guarded(o, w, s, f, d, sv, im)) r = 0;
                else if (sgn)              r = 64'(sa % sb);
                else                       r = av % bv;
            end
            4'd13: begin
                nbytes = (im == 16) ? 2 : (im == 32) ? 4 : (im == 64) ? 8 : 0;
                if (nbytes == 0) r = d;
                else if (!w && !s) begin
                    for (int k = 0; k < nbytes; k++) r[8*k +: 8] = d[8*k +: 8];
                end else begin
                    for (int k = 0; k < nbytes; k++) r = (r << 8) | 64'(d[8*k +: 8]);
                end
            end
            default: r = 0;
        endcase
        if (!w && o != 4'd13) r = z32(r);
        return r;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic run_op(input logic [3:0] o, input bit w, input bit s,
                          input logic [15:0] f, input logic [63:0] d,
                          input logic [63:0] sv, input logic [31:0] im,
                          output logic [63:0] res, output int lat);
        @(negedge clk);
        op = o; wide = w; src_sel = s; off = f; dst_val = d; src_val = sv; imm = im;
        start = 1'b1;
        lat = 0;
        do begin
            @(negedge clk);
            start = 1'b0;
            lat++;
        end while (!done && lat < 300);
        res = result;
    endtask

    task automatic one(input logic [3:0] o, input bit w, input bit s,
                       input logic [15:0] f, input logic [63:0] d,
                       input logic [63:0] sv, input logic [31:0] im, input string tag);
        logic [63:0] res, exp;
        int lat, elat;
        run_op(o, w, s, f, d, sv, im, res, lat);
        exp  = model(o, w, s, f, d, sv, im);
        elat = ((o == 4'd3 || o == 4'd9) && !guarded(o, w, s, f, d, sv, im)) ? 65 : 1;
        chk(res === exp, tag, res, exp);
        chk(lat == elat, "R11 latency", 64'(lat), 64'(elat));
    endtask

    initial begin
        #1900us;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [63:0] r0, r1;
        int lat;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(busy == 1'b0 && done == 1'b0, "R1 reset flags", {62'd0, busy, done}, 64'd0);
        chk(result == 64'd0, "R1 reset result", result, 64'd0);
        rst_n = 1'b1;

        // R3 R4 R2 R9: register-source sweep of one-cycle ops
        foreach (vals[i]) foreach (vals[j]) for (int w = 0; w < 2; w++) begin
            one(4'd0, w[0], 1'b1, 16'd0, vals[i], vals[j], 32'd0, "R3 add");
            one(4'd1, w[0], 1'b1, 16'd0, vals[i], vals[j], 32'd0, "R3 sub");
            one(4'd2, w[0], 1'b1, 16'd0, vals[i], vals[j], 32'd0, "R3 mul");
            one(4'd4, w[0], 1'b1, 16'd0, vals[i], vals[j], 32'd0, "R3 or");
            one(4'd5, w[0], 1'b1, 16'd0, vals[i], vals[j], 32'd0, "R3 and");
            one(4'd10, w[0], 1'b1, 16'd0, vals[i], vals[j], 32'd0, "R3 xor");
            one(4'd8, w[0], 1'b0, 16'd0, vals[i], vals[j], 32'd0, "R3 neg");
            one(4'd11, w[0], 1'b1, 16'd0, vals[i], vals[j], 32'd0, "R3 mov");
            one(4'd6, w[0], 1'b1, 16'd0, vals[i], vals[j], 32'd0, "R4 lsh");
            one(4'd7, w[0], 1'b1, 16'd0, vals[i], vals[j], 32'd0, "R4 rsh");
            one(4'd12, w[0], 1'b1, 16'd0, vals[i], vals[j], 32'd0, "R4 arsh");
            one(4'd11, w[0], 1'b0, 16'd8, vals[i], vals[j], 32'd5, "R9 movsx8");
            one(4'd11, w[0], 1'b1, 16'd16, vals[i], vals[j], 32'd0, "R9 movsx16");
            one(4'd11, w[0], 1'b1, 16'd32, vals[i], vals[j], 32'd0, "R9 movsx32");
        end

        // R6 R7 R8: divide and modulus, unsigned and signed
        foreach (vals[i]) foreach (vals[j]) for (int w = 0; w < 2; w++)
            for (int sg = 0; sg < 2; sg++) begin
                one(4'd3, w[0], 1'b1, 16'(sg), vals[i], vals[j], 32'd0, "R6 R7 R8 div");
                one(4'd9, w[0], 1'b1, 16'(sg), vals[i], vals[j], 32'd0, "R6 R7 R8 mod");
            end

        // R5: immediate source
        foreach (vals[i]) foreach (imms[j]) for (int w = 0; w < 2; w++) begin
            one(4'd0, w[0], 1'b0, 16'd0, vals[i], 64'hDEAD, imms[j], "R5 add imm");
            one(4'd5, w[0], 1'b0, 16'd0, vals[i], 64'hDEAD, imms[j], "R5 and imm");
            one(4'd6, w[0], 1'b0, 16'd0, vals[i], 64'hDEAD, imms[j], "R5 lsh imm");
            one(4'd11, w[0], 1'b0, 16'd0, vals[i], 64'hDEAD, imms[j], "R5 mov imm");
            one(4'd3, w[0], 1'b0, 16'd0, vals[i], 64'hDEAD, imms[j], "R5 udiv imm");
            one(4'd9, w[0], 1'b0, 16'd1, vals[i], 64'hDEAD, imms[j], "R5 smod imm");
        end

        // R10: byte conversion
        foreach (vals[i]) for (int w = 0; w < 2; w++) for (int s = 0; s < 2; s++) begin
            one(4'd13, w[0], s[0], 16'd0, vals[i], 64'd0, 32'd16, "R10 end16");
            one(4'd13, w[0], s[0], 16'd0, vals[i], 64'd0, 32'd32, "R10 end32");
            one(4'd13, w[0], s[0], 16'd0, vals[i], 64'd0, 32'd64, "R10 end64");
            one(4'd13, w[0], s[0], 16'd0, vals[i], 64'd0, 32'd24, "R10 end bad width");
        end

        // R6: truncating signed remainder, -13 rem 3 = -1
        run_op(4'd9, 1'b1, 1'b1, 16'd1, 64'hFFFF_FFFF_FFFF_FFF3, 64'd3, 32'd0, r0, lat);
        chk(r0 == 64'hFFFF_FFFF_FFFF_FFFF, "R6 -13 rem 3", r0, 64'hFFFF_FFFF_FFFF_FFFF);

        // R13: result holds while idle
        repeat (5) @(negedge clk);
        chk(result == r0 && !done, "R13 hold", result, r0);

        // R12: start during busy ignored
        @(negedge clk);
        op = 4'd3; wide = 1'b1; src_sel = 1'b1; off = 16'd0;
        dst_val = 64'd1000; src_val = 64'd7; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        repeat (9) begin @(negedge clk); lat++; end
        op = 4'd0; dst_val = 64'd5; src_val = 64'd6; start = 1'b1;
        @(negedge clk); start = 1'b0; lat++;
        while (!done && lat < 300) begin @(negedge clk); lat++; end
        chk(result == 64'd142, "R12 busy start ignored", result, 64'd142);
        chk(lat == 65, "R12 timing kept", 64'(lat), 64'd65);
        r1 = result;
        @(negedge clk);
        chk(!done && result == r1, "R12 no extra done", {63'd0, done}, 64'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule